// File: doc/BRIEF.md
# Display Identification Table Responder on a Two-Wire Bus

This block answers a host that bit-bangs the two display-channel wires (clock and data) through general-purpose pins. Each time the host updates its pin outputs, it presents one sample to the block. The sample carries an output-enable and a level for each wire. A wire whose enable is low is treated as pulled up, so it reads as high. The block acts as a bus target at 7-bit address 0x50. It recognises START and STOP conditions and shifts in the address byte and a register offset byte. It then streams a 128-byte identification table, most significant bit first, starting at byte 0.

After every sample the block updates a registered 16-bit readback word, which the host reads to see the bus. Bit 12 of this word is the clock wire and bit 13 is the data wire. Neither the clock nor the data bit is the plain input level. The clock bit is the clock level after pull-up resolution. The data bit is the resolved host level, except on the sample where the clock rises during an acknowledge or read-data phase. On that sample the target's own bit replaces it. The first eight table bytes are the fixed header 00 FF FF FF FF FF FF 00. Every later byte i holds (37*i + 11) mod 256.

Top module: `ddc_id_target`

## Requirements
- R1: After reset the readback word is 0x3000: bits 13 and 12 are 1 and every other bit is 0.
- R2: A wire whose enable is low resolves to 1, and a driven wire resolves to its level. The readback word shows the resolved clock at bit 12 and always keeps bits other than 12 and 13 at 0. Bit 13 shows the resolved host data on every sample except one kind: a sample where the clock rises during an acknowledge or read-data phase.
- R3: Data falling while the resolved clock is high is a START, which begins address reception with a bit count of zero. Data rising while the clock is high is a STOP, after which the target drives nothing. A sample in which data changes never shifts a bit, even if the clock rises in the same sample.
- R4: The address byte is taken MSB first, one bit per rising clock. On the ninth rising clock, readback bit 13 is 0 (ACK) when the upper seven address bits equal 0x50 and 1 (NACK) for any other address.
- R5: When the address read bit (bit 0) is 0, the next byte is a register offset. Offset 0x00 gets ACK (bit 13 = 0) on its ninth rising clock, and any other offset gets NACK (bit 13 = 1).
- R6: When the address read bit is 1, the target sends table bytes starting at byte 0. Each bit is sent MSB first and appears in readback bit 13 on the sample where the clock rises.
- R7: A host acknowledge of 0 on the ninth clock of a read byte loads the next table byte. An acknowledge of 1 loads nothing and leaves the table index where it was. After such an acknowledge of 1, the following eight bits read as 0.
- R8: The table index wraps from byte 127 back to byte 0.
- R9: In the write direction after the offset, the target leaves the data bits to the host, so readback bit 13 equals the host bit. The target answers each received byte with ACK (bit 13 = 0).
- R10: A START inside a transfer (a repeated START) restarts the transfer, and a read that follows it begins again at table byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe: a new pin sample is present |
| scl_oe | input | 1 | Host drives the clock wire |
| scl_o | input | 1 | Clock level when driven |
| sda_oe | input | 1 | Host drives the data wire |
| sda_o | input | 1 | Data level when driven |
| readback | output | 16 | Registered bus view: bit 12 clock, bit 13 data |

## Verification
The bench sweeps all 256 address bytes and all 256 offset bytes. A decoder that compared all eight address bits, or skipped the read bit, would acknowledge the wrong set. The bench places a sample where the clock rises together with a falling data line in the middle of an address, and then sends a clean address. A design that let the edge win would shift a stray bit and lose the acknowledge. The bench also reads across byte 127, and it NACKs once in the middle of a read. A pointer that did not wrap, or one that advanced on a NACK, would return the wrong table bytes afterwards.

// File: rtl/ddc_id_pkg.sv
package ddc_id_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_OFFS,
    ST_DATA,
    ST_ACK
  } ddc_st_e;

  // Identification table content: fixed header, then an arithmetic fill.
  function automatic logic [7:0] tbl_byte(input int unsigned idx);
    int unsigned v;
    if (idx < 8) begin
      tbl_byte = (idx == 0 || idx == 7) ? 8'h00 : 8'hFF;
    end else begin
      v = (idx * 37 + 11) % 256;
      tbl_byte = v[7:0];
    end
  endfunction

endpackage

// File: rtl/ddc_id_rom.sv
module ddc_id_rom #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [7:0]    q
);
  import ddc_id_pkg::*;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = tbl_byte(i);
  end

  // Registered read keeps the table block-RAM friendly.
  always_ff @(posedge clk) q <= mem[addr];

endmodule

// File: rtl/ddc_bus_fsm.sv
module ddc_bus_fsm #(
  parameter int DEPTH = 128,
  parameter logic [6:0] DEV_ID7 = 7'h50,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [7:0]    rom_q,
  output logic [AW-1:0] ptr,
  output logic          scl_q,
  output logic          sda_q
);
  import ddc_id_pkg::*;

  ddc_st_e st, pst, n_st, n_pst;
  logic [2:0] cnt, n_cnt;
  logic [7:0] shreg, n_sh, dev, n_dev, offs, n_off;
  logic [AW-1:0] n_ptr;
  logic n_sda;
  logic rise, chg;

  // History of both wires is the last readback value itself.
  assign rise = scl_i && !scl_q;
  assign chg  = (sda_i != sda_q);

  always_comb begin
    n_st = st; n_pst = pst; n_cnt = cnt; n_sh = shreg;
    n_dev = dev; n_off = offs; n_ptr = ptr; n_sda = sda_i;
    if (chg) begin
      if (scl_i) begin
        if (!sda_i) begin
          n_st = ST_ADDR; n_cnt = '0; n_ptr = '0;
        end else begin
          n_st = ST_IDLE;
        end
      end
    end else if (rise) begin
      unique case (st)
        ST_IDLE: ;
        ST_ADDR, ST_OFFS: begin
          n_sh = {shreg[6:0], sda_q};
          if (cnt == 3'd7) begin
            n_cnt = '0; n_pst = st; n_st = ST_ACK;
            if (st == ST_ADDR) n_dev = n_sh;
            else               n_off = n_sh;
          end else begin
            n_cnt = cnt + 3'd1;
          end
        end
        ST_DATA: begin
          if (dev[0]) n_sda = shreg[3'd7 - cnt];
          if (cnt == 3'd7) begin
            n_cnt = '0; n_pst = ST_DATA; n_st = ST_ACK;
          end else begin
            n_cnt = cnt + 3'd1;
          end
        end
        ST_ACK: begin
          n_cnt = '0;
          n_sh  = '0;
          unique case (pst)
            ST_ADDR: begin
              n_sda = (dev[7:1] == DEV_ID7) ? 1'b0 : 1'b1;
              if (dev[0]) begin
                n_st = ST_DATA; n_sh = rom_q; n_ptr = ptr + 1'b1;
              end else begin
                n_st = ST_OFFS;
              end
            end
            ST_OFFS: begin
              n_st  = ST_DATA;
              n_sda = (offs == 8'h00) ? 1'b0 : 1'b1;
            end
            default: begin
              n_st = ST_DATA;
              if (dev[0]) begin
                if (!sda_i) begin
                  n_sh = rom_q; n_ptr = ptr + 1'b1;
                end
              end else begin
                n_sda = 1'b0;
              end
            end
          endcase
        end
        default: n_st = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; pst <= ST_IDLE; cnt <= '0; shreg <= '0;
      dev <= '0; offs <= '0; ptr <= '0; scl_q <= 1'b1; sda_q <= 1'b1;
    end else if (smp) begin
      st <= n_st; pst <= n_pst; cnt <= n_cnt; shreg <= n_sh;
      dev <= n_dev; offs <= n_off; ptr <= n_ptr;
      scl_q <= scl_i; sda_q <= n_sda;
    end
  end

  assert_start_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (smp && chg && scl_i && !sda_i) |=> (st == ST_ADDR && cnt == 3'd0 && ptr == '0));

  assert_stop_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (smp && chg && scl_i && sda_i) |=> (st == ST_IDLE));

  assert_no_shift_on_change_R3: assert property (@(posedge clk) disable iff (rst)
    (smp && chg) |=> $stable(shreg));

  assert_host_passthru_R2: assert property (@(posedge clk) disable iff (rst)
    (smp && (chg || !rise || st == ST_IDLE)) |=> (sda_q == $past(sda_i)));

  assert_addr_answer_R4: assert property (@(posedge clk) disable iff (rst)
    (smp && rise && !chg && st == ST_ACK && pst == ST_ADDR)
      |=> (sda_q == ($past(dev[7:1]) != DEV_ID7)));

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(ptr) |-> (ptr == '0 || ptr == AW'($past(ptr) + 1'b1)));

endmodule

// File: rtl/ddc_id_target.sv
module ddc_id_target #(
  parameter int TBL_DEPTH = 128,
  parameter logic [6:0] DEV_ID7 = 7'h50,
  parameter int RB_W = 16,
  parameter int SCL_POS = 12,
  parameter int SDA_POS = 13,
  localparam int AW = $clog2(TBL_DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smp_valid,
  input  logic            scl_oe,
  input  logic            scl_o,
  input  logic            sda_oe,
  input  logic            sda_o,
  output logic [RB_W-1:0] readback
);

  logic scl_r, sda_r, scl_q, sda_q;
  logic [AW-1:0] ptr;
  logic [7:0] rom_q;

  // Undriven wires are pulled up.
  assign scl_r = scl_oe ? scl_o : 1'b1;
  assign sda_r = sda_oe ? sda_o : 1'b1;

  ddc_id_rom #(.DEPTH(TBL_DEPTH)) u_rom (
    .clk  (clk),
    .addr (ptr),
    .q    (rom_q)
  );

  ddc_bus_fsm #(.DEPTH(TBL_DEPTH), .DEV_ID7(DEV_ID7)) u_fsm (
    .clk   (clk),
    .rst   (rst),
    .smp   (smp_valid),
    .scl_i (scl_r),
    .sda_i (sda_r),
    .rom_q (rom_q),
    .ptr   (ptr),
    .scl_q (scl_q),
    .sda_q (sda_q)
  );

  always_comb begin
    readback = '0;
    readback[SCL_POS] = scl_q;
    readback[SDA_POS] = sda_q;
  end

  assert_rb_idle_bits_R1: assert property (@(posedge clk)
    $past(rst) |-> (readback == RB_W'(1 << SCL_POS | 1 << SDA_POS)));

endmodule

// File: tb/ddc_id_target_tb.sv
module ddc_id_target_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic scl_oe = 1'b1, scl_o = 1'b1, sda_oe = 1'b1, sda_o = 1'b1;
  logic [15:0] readback;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ddc_id_target u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid),
    .scl_oe(scl_oe), .scl_o(scl_o), .sda_oe(sda_oe), .sda_o(sda_o),
    .readback(readback)
  );

  function automatic logic [7:0] exp_byte(input int i);
    int v;
    if (i < 8) return (i == 0 || i == 7) ? 8'h00 : 8'hFF;
    v = (i * 37 + 11) % 256;
    return v[7:0];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic ce, input logic cv, input logic de, input logic dv,
                       output logic [15:0] r);
    @(negedge clk);
    scl_oe = ce; scl_o = cv; sda_oe = de; sda_o = dv; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    r = readback;
  endtask

  task automatic t_start();
    logic [15:0] r;
    drive(1, 0, 1, 1, r); drive(1, 1, 1, 1, r);
    drive(1, 1, 1, 0, r); drive(1, 0, 1, 0, r);
  endtask

  task automatic t_stop();
    logic [15:0] r;
    drive(1, 0, 1, 0, r); drive(1, 1, 1, 0, r); drive(1, 1, 1, 1, r);
  endtask

  task automatic t_bit(input logic de, input logic dv, output logic seen);
    logic [15:0] r;
    drive(1, 0, de, dv, r);
    drive(1, 1, de, dv, r);
    seen = r[13];
    drive(1, 0, de, dv, r);
  endtask

  task automatic t_wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) t_bit(1, b[i], s);
    t_bit(0, 1, ack);
  endtask

  task automatic t_rbyte(input logic host_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      t_bit(0, 1, s);
      d[i] = s;
    end
    if (host_ack) t_bit(1, 0, s);
    else          t_bit(0, 1, s);
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic ack, s;
    logic [7:0] d;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset readback", readback, 16'h3000);

    // R2: resolution of released and driven wires
    drive(0, 0, 0, 0, r); check("R2 both released", r, 16'h3000);
    drive(1, 0, 1, 1, r); check("R2 scl driven low", r, 16'h2000);
    drive(1, 0, 1, 0, r); check("R2 both driven low", r, 16'h0000);
    drive(1, 1, 1, 0, r); check("R2 scl driven high", r, 16'h1000);
    drive(0, 0, 1, 0, r); check("R2 scl released", r, 16'h1000);
    drive(0, 0, 0, 0, r); check("R2 sda released", r, 16'h3000);

    // R4: exhaustive address sweep
    for (int a = 0; a < 256; a++) begin
      t_start();
      t_wbyte(8'(a), ack);
      check($sformatf("R4 address %0h answer", a), ack, (a[7:1] == 7'h50) ? 0 : 1);
      t_stop();
    end

    // R5: exhaustive offset sweep
    for (int o = 0; o < 256; o++) begin
      t_start();
      t_wbyte(8'hA0, ack);
      t_wbyte(8'(o), ack);
      check($sformatf("R5 offset %0h answer", o), ack, (o == 0) ? 0 : 1);
      t_stop();
    end

    // R9: write data left to host and acknowledged
    t_start();
    t_wbyte(8'hA0, ack);
    t_wbyte(8'h00, ack);
    for (int k = 0; k < 2; k++) begin
      logic [7:0] wb;
      logic [7:0] seen_b;
      wb = (k == 0) ? 8'h5A : 8'hC3;
      for (int i = 7; i >= 0; i--) begin
        t_bit(1, wb[i], s);
        seen_b[i] = s;
      end
      check("R9 write bits follow host", seen_b, wb);
      t_bit(0, 1, ack);
      check("R9 write byte acknowledged", ack, 0);
    end
    t_stop();

    // R6 R7 R8: read stream with one NACK and a wrap
    t_start();
    t_wbyte(8'hA1, ack);
    check("R4 read address ack", ack, 0);
    for (int i = 0; i < 9; i++) begin
      t_rbyte(i != 8, d);
      check($sformatf("R6 table byte %0d", i), d, exp_byte(i));
    end
    t_rbyte(1, d);
    check("R7 byte after NACK reads zero", d, 0);
    for (int i = 9; i < 130; i++) begin
      t_rbyte(i != 129, d);
      if (i < 128) check($sformatf("R7 table byte %0d", i), d, exp_byte(i));
      else         check($sformatf("R8 wrapped byte %0d", i), d, exp_byte(i % 128));
    end
    t_stop();

    // R10: repeated START after offset, read restarts at byte 0
    t_start();
    t_wbyte(8'hA0, ack);
    t_wbyte(8'h00, ack);
    t_start();
    t_wbyte(8'hA1, ack);
    check("R10 address after repeated start", ack, 0);
    for (int i = 0; i < 9; i++) begin
      t_rbyte(i != 8, d);
      check($sformatf("R10 byte %0d after restart", i), d, exp_byte(i));
    end
    t_stop();

    // R3: clock rise with falling data acts as START, no stray shift
    t_start();
    t_bit(1, 1, s); t_bit(1, 0, s); t_bit(1, 1, s);
    drive(1, 0, 1, 1, r);
    drive(1, 1, 1, 0, r);
    drive(1, 0, 1, 0, r);
    t_wbyte(8'hA1, ack);
    check("R3 change wins over edge, address aligned", ack, 0);
    t_stop();

    // R3: clock rise with rising data acts as STOP, then target is quiet
    t_start();
    t_bit(1, 1, s); t_bit(1, 0, s);
    drive(1, 0, 1, 0, r);
    drive(1, 1, 1, 1, r);
    check("R3 stop sample readback", r, 16'h3000);
    drive(1, 0, 1, 1, r);
    t_wbyte(8'hA0, ack);
    check("R3 no answer after stop", ack, 1);
    t_bit(1, 0, s);
    check("R3 idle follows host low", s, 0);
    t_stop();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule